// File: doc/BRIEF.md
# Memory-Mapped Configuration and Register Port

This block sits between a host processor and a small array of reconfigurable cells. The processor sees a 16-bit address space through a single read/write port. In that space it can reach two things: the configuration byte of every cell, and the single user register bit that each cell holds. A cell is named by a column and a row. The cell at column `c`, row `r` has configuration index `c*ROWS + r`. A few reserved control words set up how transfers behave: the usable data bus width, a row-select map for register transfers, and a wildcard mask for broadcast writes.

A register transfer addresses one whole column. The rows whose map bit is set are packed, lowest row first, onto consecutive data bits starting at bit 0. Software can therefore read or write a user register scattered across arbitrary rows without any shifting or masking. Configuration transfers move one byte per cell, so one access updates as many cells as the bus has byte lanes. Any address bit that is set in the wildcard mask becomes don't-care for writes. A single write cycle then lands in every location that matches on the remaining bits.

Each access takes one clock cycle with chip select high. Read data is registered and appears on the cycle after the read.

Top module: `mmap_cfg_port`

## Requirements
- R1: After synchronous reset, the following values hold. The width code is 2 (32 bits). The row map is all ones. The wildcard mask is zero. Every configuration byte and every register bit is zero. `rdata` is zero.
- R2: Control words are decoded when addr[15]=1 and addr[14:2]=0, with addr[1:0] selecting the word. Code 0 is the row map (low ROWS bits). Code 1 is the 16-bit wildcard mask. Code 2 is the width code (bits 1:0: 0 means 8 bits, 1 means 16 bits, 2 or 3 means 32 bits). Code 3 reads as zero. Control words read back their stored value. On a control write, data bits above the current bus width are taken as zero.
- R3: A read with `cs`=1 and `rnw`=1 in cycle N presents its data on `rdata` in cycle N+1. After any cycle that is not a read, `rdata` is zero.
- R4: Configuration space is addr[15:14]=00 with addr[13:6]=0, and the cell index is addr[5:0]. With n = width/8 byte lanes, the group base is the index with its low log2(n) bits cleared. Byte lane k (data bits 8k+7..8k) maps to cell base+k.
- R5: Register space is addr[15:14]=01 with addr[13:2]=0, and addr[1:0] selects the column. Each column holds 16 register bits, one per row.
- R6: A register read returns the bits of the mapped rows, in ascending row order, on data bits 0, 1, 2 and so on.
- R7: A register write loads the mapped rows, in ascending order, from data bits 0, 1, 2 and so on. Rows whose map bit is clear keep their value.
- R8: Read data bits at or above the bus width are zero. Write data bits at or above the bus width are ignored. A mapped row whose packed position is at or above the width keeps its value, and byte lanes beyond the width write nothing.
- R9: Wildcard mask bit i makes address bit i don't-care for configuration writes. Every cell group whose index matches the address on the unmasked bits is written in the same cycle.
- R10: For register writes, wildcard bits 1:0 make column bits don't-care. Every matching column is written with the same packed data.
- R11: Reads ignore broadcast. A read returns the location whose address has every wildcard-masked bit taken as zero.
- R12: With `cs` low, or with an address that matches no space, no stored state changes and the read result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select; one access per cycle while high |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Access address |
| wdata | input | 32 | Write data from the processor |
| rdata | output | 32 | Registered read data, valid the cycle after a read |

## Verification
The bench targets packing with sparse maps, where a design that kept row positions instead of compacting them would return bits in the wrong places. It also targets narrow widths: a design that truncated too late would overwrite rows or cells from bus bits that software never drove. Broadcast writes with group-aligned wildcards are compared with later reads of locations other than the one addressed, which exposes a design that writes only the literal address. Reads under an active mask, unmapped addresses and deselected cycles catch designs that would alias, corrupt state or leave stale data on the bus.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 16;

    // Width code held in the control space
    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } bw_e;

    // Which part of the address map an access lands in
    typedef enum logic [1:0] {
        SP_NONE,
        SP_CFG,
        SP_REG,
        SP_CTRL
    } space_e;

    // Control word selector, addr[1:0] inside the control space
    typedef enum logic [1:0] {
        CR_MAP   = 2'd0,
        CR_WILD  = 2'd1,
        CR_WIDTH = 2'd2,
        CR_RSVD  = 2'd3
    } ctrl_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        space_e            space;
        logic [BUS_W-1:0]  wdata;
    } req_t;

    function automatic logic [5:0] bus_bits(logic [1:0] code);
        case (code)
            BW_8:    return 6'd8;
            BW_16:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] bus_mask(logic [1:0] code);
        case (code)
            BW_8:    return 32'h0000_00FF;
            BW_16:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Low index bits that pick a byte lane inside one group
    function automatic logic [1:0] lane_mask(logic [1:0] code);
        case (code)
            BW_8:    return 2'b00;
            BW_16:   return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [15:0]      wdata,
    output logic [ROWS-1:0]  map_o,
    output logic [15:0]      wild_o,
    output logic [1:0]       wsel_o,
    output logic [BUS_W-1:0] rd_data
);

    logic [ROWS-1:0] map_q;
    logic [15:0]     wild_q;
    logic [1:0]      wsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q  <= '1;
            wild_q <= '0;
            wsel_q <= BW_32;
        end else if (wr) begin
            case (ctrl_e'(sel))
                CR_MAP:   map_q  <= wdata[ROWS-1:0];
                CR_WILD:  wild_q <= wdata;
                CR_WIDTH: wsel_q <= wdata[1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (ctrl_e'(sel))
            CR_MAP:   rd_data = BUS_W'(map_q);
            CR_WILD:  rd_data = BUS_W'(wild_q);
            CR_WIDTH: rd_data = BUS_W'(wsel_q);
            default:  rd_data = '0;
        endcase
    end

    assign map_o  = map_q;
    assign wild_o = wild_q;
    assign wsel_o = wsel_q;

    // R2: control words only move on a control write
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(map_q) && $stable(wild_q) && $stable(wsel_q)));

endmodule

// File: rtl/cfgport_cfgmem.sv
module cfgport_cfgmem
    import cfgport_pkg::*;
#(
    parameter int CELLS = 64,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] wild,
    input  logic [1:0]       lm,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rd_data
);

    logic [7:0]       mem [CELLS];
    logic [CELLS-1:0] hit;
    logic [1:0]       lane [CELLS];
    logic [IDX_W-1:0] lm_x;

    assign lm_x = IDX_W'(lm);

    // Broadcast match: lane bits and wildcard bits are don't-care
    always_comb begin
        for (int c = 0; c < CELLS; c++) begin
            hit[c]  = (((IDX_W'(c) ^ idx) & ~lm_x & ~wild) == '0);
            lane[c] = 2'(c) & lm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < CELLS; c++) mem[c] <= '0;
        end else if (wr) begin
            for (int c = 0; c < CELLS; c++) begin
                if (hit[c]) mem[c] <= wdata[{lane[c], 3'b000} +: 8];
            end
        end
    end

    // Reads take wildcard bits as zero and start at the group base
    logic [IDX_W-1:0] base;
    assign base = idx & ~wild & ~lm_x;

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 4; k++) begin
            if (2'(k) <= lm) rd_data[8*k +: 8] = mem[base | IDX_W'(k)];
        end
    end

    // R12: storage is untouched in cycles with no configuration write
    assert_cfg_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(mem[0]) && $stable(mem[CELLS-1])));

endmodule

// File: rtl/cfgport_cellgrid.sv
module cfgport_cellgrid
    import cfgport_pkg::*;
#(
    parameter int COLS = 4,
    parameter int ROWS = 16,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] wild,
    input  logic [ROWS-1:0]  map,
    input  logic [5:0]       nbits,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rd_data
);

    logic [ROWS-1:0] grid [COLS];
    logic [ROWS-1:0] nxt  [COLS];
    logic [COL_W-1:0] rcol;

    assign rcol = col & ~wild;

    // Gather mapped rows onto contiguous low bus bits
    always_comb begin
        int n;
        n = 0;
        rd_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (map[r]) begin
                if (n < BUS_W) rd_data[n[4:0]] = grid[rcol][r];
                n++;
            end
        end
    end

    // Scatter contiguous bus bits back into mapped rows of each matching column
    always_comb begin
        int n;
        for (int c = 0; c < COLS; c++) begin
            nxt[c] = grid[c];
            n = 0;
            if (((COL_W'(c) ^ col) & ~wild) == '0) begin
                for (int r = 0; r < ROWS; r++) begin
                    if (map[r]) begin
                        if (n < int'(nbits)) nxt[c][r] = wdata[n[4:0]];
                        n++;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < COLS; c++) grid[c] <= '0;
        end else if (wr) begin
            for (int c = 0; c < COLS; c++) grid[c] <= nxt[c];
        end
    end

    // R7: rows outside the map never change on a write
    for (genvar gc = 0; gc < COLS; gc++) begin : g_hold
        assert_unmapped_hold_R7: assert property (@(posedge clk) disable iff (rst)
            wr |=> (((grid[gc] ^ $past(grid[gc])) & ~$past(map)) == '0));
    end

endmodule

// File: rtl/mmap_cfg_port.sv
module mmap_cfg_port
    import cfgport_pkg::*;
#(
    parameter int COLS = 4,
    parameter int ROWS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs,
    input  logic        rnw,
    input  logic [15:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam int CELLS = COLS * ROWS;
    localparam int IDX_W = $clog2(CELLS);
    localparam int COL_W = $clog2(COLS);

    req_t            req;
    logic [1:0]      wsel;
    logic [ROWS-1:0] map;
    logic [15:0]     wild;
    logic [31:0]     ctrl_rd, cfg_rd, reg_rd, rd_sel;

    // Address decode; upper bits inside a space must be zero to hit
    always_comb begin
        req.rd    = cs & rnw;
        req.wr    = cs & ~rnw;
        req.wdata = wdata & bus_mask(wsel);
        if (addr[15] && addr[14:2] == '0)
            req.space = SP_CTRL;
        else if (addr[15:14] == 2'b00 && addr[13:IDX_W] == '0)
            req.space = SP_CFG;
        else if (addr[15:14] == 2'b01 && addr[13:COL_W] == '0)
            req.space = SP_REG;
        else
            req.space = SP_NONE;
    end

    cfgport_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (req.wr && req.space == SP_CTRL),
        .sel     (addr[1:0]),
        .wdata   (req.wdata[15:0]),
        .map_o   (map),
        .wild_o  (wild),
        .wsel_o  (wsel),
        .rd_data (ctrl_rd)
    );

    cfgport_cfgmem #(.CELLS(CELLS)) u_cfgmem (
        .clk     (clk),
        .rst     (rst),
        .wr      (req.wr && req.space == SP_CFG),
        .idx     (addr[IDX_W-1:0]),
        .wild    (wild[IDX_W-1:0]),
        .lm      (lane_mask(wsel)),
        .wdata   (req.wdata),
        .rd_data (cfg_rd)
    );

    cfgport_cellgrid #(.COLS(COLS), .ROWS(ROWS)) u_grid (
        .clk     (clk),
        .rst     (rst),
        .wr      (req.wr && req.space == SP_REG),
        .col     (addr[COL_W-1:0]),
        .wild    (wild[COL_W-1:0]),
        .map     (map),
        .nbits   (bus_bits(wsel)),
        .wdata   (req.wdata),
        .rd_data (reg_rd)
    );

    always_comb begin
        case (req.space)
            SP_CTRL: rd_sel = ctrl_rd;
            SP_CFG:  rd_sel = cfg_rd;
            SP_REG:  rd_sel = reg_rd;
            default: rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_sel & bus_mask(wsel);
        else             rdata <= '0;
    end

    // R3: bus returns to zero after a cycle without a read
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !(cs && rnw) |=> (rdata == '0));

    // R8: nothing shows above the width in force when the read was taken
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rdata & ~bus_mask($past(wsel))) == '0));

endmodule

// File: tb/mmap_cfg_port_tb_top.sv
module mmap_cfg_port_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs;
    logic        rnw;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;

    always #5 clk = ~clk;

    mmap_cfg_port dut_i (
        .clk(clk), .rst(rst), .cs(cs), .rnw(rnw),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard queues
    int          q_due [$];
    logic [31:0] q_exp [$];
    string       q_tag [$];
    logic [15:0] q_adr [$];

    // Reference state, from the requirements
    logic [7:0]  m_cfg [64];
    logic [15:0] m_grid [4];
    logic [15:0] m_map;
    logic [15:0] m_wild;
    logic [1:0]  m_ws;

    function automatic int m_bits();
        return (m_ws == 2'd0) ? 8 : (m_ws == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] m_mask();
        return (m_ws == 2'd0) ? 32'hFF : (m_ws == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [5:0] m_lm();
        return (m_ws == 2'd0) ? 6'd0 : (m_ws == 2'd1) ? 6'd1 : 6'd3;
    endfunction

    // 0 none, 1 cfg, 2 reg, 3 ctrl
    function automatic int m_space(logic [15:0] a);
        if (a[15] && a[14:2] == 0) return 3;
        if (a[15:14] == 2'b00 && a[13:6] == 0) return 1;
        if (a[15:14] == 2'b01 && a[13:2] == 0) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(logic [15:0] a);
        logic [31:0] o = '0;
        logic [5:0]  b;
        logic [1:0]  c;
        int n = 0;
        case (m_space(a))
            3: case (a[1:0])
                   2'd0: o = {16'h0, m_map};
                   2'd1: o = {16'h0, m_wild};
                   2'd2: o = {30'h0, m_ws};
                   default: o = '0;
               endcase
            1: begin
                b = a[5:0] & ~m_wild[5:0] & ~m_lm();
                for (int k = 0; k < 4; k++)
                    if (k <= int'(m_lm())) o[8*k +: 8] = m_cfg[b | 6'(k)];
            end
            2: begin
                c = a[1:0] & ~m_wild[1:0];
                for (int r = 0; r < 16; r++)
                    if (m_map[r]) begin o[n] = m_grid[c][r]; n++; end
            end
            default: o = '0;
        endcase
        return o & m_mask();
    endfunction

    function automatic void m_write(logic [15:0] a, logic [31:0] din);
        logic [31:0] d = din & m_mask();
        logic [5:0]  keep;
        int n;
        case (m_space(a))
            3: case (a[1:0])
                   2'd0: m_map  = d[15:0];
                   2'd1: m_wild = d[15:0];
                   2'd2: m_ws   = d[1:0];
                   default: ;
               endcase
            1: begin
                keep = ~m_lm() & ~m_wild[5:0];
                for (int c = 0; c < 64; c++)
                    if (((6'(c) ^ a[5:0]) & keep) == 0)
                        m_cfg[c] = d[8*(c & int'(m_lm())) +: 8];
            end
            2: begin
                for (int c = 0; c < 4; c++)
                    if (((2'(c) ^ a[1:0]) & ~m_wild[1:0]) == 0) begin
                        n = 0;
                        for (int r = 0; r < 16; r++)
                            if (m_map[r]) begin
                                if (n < m_bits()) m_grid[c][r] = d[n];
                                n++;
                            end
                    end
            end
            default: ;
        endcase
    endfunction

    // Driver: one access per cycle, expected result pushed for the next cycle
    task automatic acc(input bit sel, input bit rd, input logic [15:0] a,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        cs = sel; rnw = rd; addr = a; wdata = d;
        q_due.push_back(cyc + 1);
        q_exp.push_back((sel && rd) ? m_read(a) : 32'h0);
        q_tag.push_back(tag);
        q_adr.push_back(a);
        if (sel && !rd) m_write(a, d);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        acc(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        acc(1'b1, 1'b1, a, 32'h0, tag);
    endtask

    // Monitor: compare results in the cycle they are due
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            tests++;
            if (rdata !== q_exp[0]) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h",
                         q_tag[0], q_adr[0], rdata, q_exp[0]);
            end
            void'(q_due.pop_front()); void'(q_exp.pop_front());
            void'(q_tag.pop_front()); void'(q_adr.pop_front());
        end
    end

    localparam logic [15:0] A_MAP = 16'h8000, A_WILD = 16'h8001,
                            A_WID = 16'h8002, A_RSV = 16'h8003;

    initial begin
        for (int c = 0; c < 64; c++) m_cfg[c] = 8'h0;
        for (int c = 0; c < 4; c++) m_grid[c] = 16'h0;
        m_map = 16'hFFFF; m_wild = 16'h0; m_ws = 2'd2;
        rst = 1'b1; cs = 1'b0; rnw = 1'b1; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state, R2 control readback
        rd(A_MAP,  "R1 map");
        rd(A_WILD, "R1 wild");
        rd(A_WID,  "R1 width");
        rd(16'h0000, "R1 cfg");
        rd(16'h4003, "R1 reg");
        rd(A_RSV,  "R2 reserved");

        // R4 configuration lanes at 32 bits, then R3 back-to-back reads
        wr(16'h0004, 32'h4433_2211, "R3 write idle");
        rd(16'h0004, "R4 group 32");
        rd(16'h0006, "R4 aligned down");
        rd(16'h0005, "R3 back-to-back");
        wr(16'h0020, 32'hDEAD_BEEF, "R3 write idle");
        rd(16'h0020, "R4 second group");

        // R8 narrow widths on configuration bytes
        wr(A_WID, 32'h1, "R2 width16");
        rd(A_WID, "R2 width readback");
        wr(16'h0009, 32'hAABB_CCDD, "R8 w16");
        rd(16'h0008, "R8 cfg w16");
        wr(A_WID, 32'h0, "R2 width8");
        wr(16'h000D, 32'h1234_565A, "R8 w8");
        rd(16'h000D, "R8 cfg w8");
        rd(16'h000C, "R8 cfg neighbour");
        wr(A_MAP, 32'hFFFF_1234, "R2 map trunc");
        rd(A_MAP, "R2 map trunc");
        wr(A_WID, 32'h3, "R2 code3 is 32");
        rd(16'h0004, "R2 code3 read");
        wr(A_MAP, 32'hFFFF, "R2 map full");

        // R5 R6 R7 register packing
        wr(16'h4001, 32'h0000_BEEF, "R5 write");
        rd(16'h4001, "R5 readback");
        wr(16'h4003, 32'hFFFF, "R7 preload");
        wr(A_MAP, 32'h0000_8421, "R6 sparse map");
        wr(16'h4002, 32'hFFFF_FFF5, "R7 sparse write");
        rd(16'h4002, "R6 sparse read");
        wr(A_MAP, 32'h0000_00F0, "R7 map");
        wr(16'h4003, 32'h0, "R7 unmapped hold");
        wr(A_MAP, 32'hFFFF, "R7 map full");
        rd(16'h4002, "R7 full view c2");
        rd(16'h4003, "R7 full view c3");

        // R8 register truncation at 8 bits
        wr(A_WID, 32'h0, "R8 width8");
        rd(16'h4001, "R8 read trunc");
        wr(16'h4001, 32'h1234_5600, "R8 write trunc");
        wr(A_WID, 32'h2, "R8 width32");
        rd(16'h4001, "R8 upper rows kept");

        // R9 R11 wildcard on configuration
        wr(A_WILD, 32'h0030, "R9 wild set");
        wr(16'h0000, 32'hA1B2_C3D4, "R9 broadcast");
        rd(16'h0020, "R11 masked read");
        wr(A_WILD, 32'h0000, "R9 wild clear");
        rd(16'h0010, "R9 copy 1");
        rd(16'h0030, "R9 copy 3");
        rd(16'h0004, "R9 untouched");

        // R10 R11 wildcard on register columns
        wr(A_WILD, 32'h0003, "R10 wild set");
        wr(16'h4002, 32'h0000_CAFE, "R10 broadcast");
        wr(A_WILD, 32'h0001, "R11 wild one");
        wr(16'h4003, 32'h0000_0001, "R10 pair");
        rd(16'h4003, "R11 col3 as col2");
        wr(A_WILD, 32'h0000, "R10 wild clear");
        rd(16'h4000, "R10 col0");
        rd(16'h4001, "R10 col1");
        rd(16'h4003, "R10 col3");

        // R12 deselected and unmapped accesses
        acc(1'b0, 1'b0, 16'h0004, 32'h0BAD_0BAD, "R12 cs low write");
        acc(1'b0, 1'b1, 16'h0004, 32'h0, "R12 cs low read");
        rd(16'h0004, "R12 cfg kept");
        wr(16'h0104, 32'h7777_7777, "R12 unmapped write");
        wr(16'hC000, 32'h7777_7777, "R12 unmapped ctrl");
        rd(16'h0104, "R12 unmapped read");
        rd(16'h0004, "R12 cfg still kept");
        rd(A_MAP, "R12 map kept");

        acc(1'b0, 1'b1, 16'h0, 32'h0, "R3 tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule